// File: doc/BRIEF.md
# Signed-Digit Segment Bias Encoder

This block turns a signed target step number N into one three-valued command per segment of a quantized array. The array is divided into weighted segments, and each segment can be biased onto its negative step, its zero step or its positive step. The step count the whole array produces is the sum of each segment's weight times its state. A parameter picks the weights. The binary variant uses 1, 2, 4, 8 and so on. The balanced-ternary variant uses 1, 3, 9, 27 and so on, so fewer segments cover the same span.

N arrives in one of two ways. In direct mode it comes in through a valid/ready handshake. In playback mode a stored sequence of N values is read out, one entry per sample strobe, so a staircase approximation of a waveform can be played repeatedly. The sequence store is loaded through a simple write port. All segment commands are registered together and change on a single cycle, and that cycle is marked by an update pulse. A value the array cannot reach raises an error pulse and leaves the commands as they were.

Top module: `sdseg_bias_enc`

## Requirements
- R1: While playback is off, `in_ready` is high. An N accepted on a clock edge with `in_valid` high produces either an `upd` pulse with the new commands or an `err` pulse, visible after the next clock edge.
- R2: Each segment uses a 2-bit command field at bits [2i+1:2i]. The code 2'b01 means +1, 2'b00 means 0 and 2'b11 means -1. The code 2'b10 never appears.
- R3: After an update, the sum over segments of weight(i) times digit(i) equals N. The weight is 2^i when TERNARY=0 and 3^i when TERNARY=1.
- R4: With binary weights, segment i carries the sign of N when bit i of |N| is 1, and carries 0 otherwise. No command ever mixes +1 and -1 digits.
- R5: With ternary weights, the commands are the balanced-ternary digits of N. These are unique, so the sum in R3 fixes them.
- R6: An N with |N| > M is rejected. M is 2^NSEG-1 for binary weights and (3^NSEG-1)/2 for ternary weights. A rejection gives a one-cycle `err` pulse, no `upd`, and unchanged commands. This applies both to direct input and to played-back entries.
- R7: The command bus changes only in a cycle where `upd` is high. At all other times every segment holds its value.
- R8: Words written through `wr_en`/`wr_addr`/`wr_data` are stored. With `play_en` high, each `sample_tick` consumes the next stored entry, starting at entry 0, and the result appears after the next clock edge.
- R9: After entry SEQ_DEPTH-1, playback continues with entry 0.
- R10: While playback is on, `in_ready` is low and `in_valid` has no effect. While playback is off, `sample_tick` has no effect. Dropping `play_en` returns the read position to entry 0.
- R11: After reset, all commands are 0 and both `upd` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| play_en | input | 1 | Selects playback mode |
| in_valid | input | 1 | Direct N is offered |
| in_ready | output | 1 | Direct N can be taken |
| in_n | input | NW | Direct signed step number |
| sample_tick | input | 1 | Playback strobe |
| wr_en | input | 1 | Sequence store write enable |
| wr_addr | input | $clog2(SEQ_DEPTH) | Sequence store write address |
| wr_data | input | NW | Signed step number to store |
| cmd | output | 2*NSEG | Per-segment commands |
| upd | output | 1 | Commands changed this cycle |
| err | output | 1 | Last N was out of range |

## Verification
The properties assume that `play_en` alone decides which source is live, and that every response follows its trigger by exactly one edge. Under that assumption, a cycle with no accepted N and no playback strobe must be quiet. The properties also assume that a playback strobe only reaches a stored entry that has already been written. The stimulus writes the whole sequence store before it raises `play_en`. It changes inputs only at falling edges, holds each request for a single cycle, and in every mode applies the input the other mode would use, so the ignore rules are exercised.

// File: rtl/sdseg_pkg.sv
package sdseg_pkg;

  typedef enum logic [1:0] {
    DIG_ZERO = 2'b00,
    DIG_POS  = 2'b01,
    DIG_NEG  = 2'b11
  } dig_e;

  // Largest reachable magnitude: sum of all segment weights.
  function automatic int span_max(input int nseg, input bit tern);
    int w;
    int s;
    w = 1;
    s = 0;
    for (int i = 0; i < nseg; i++) begin
      s = s + w;
      w = tern ? w * 3 : w * 2;
    end
    return s;
  endfunction

endpackage

// File: rtl/sdseg_range_chk.sv
module sdseg_range_chk #(
  parameter int NW   = 8,
  parameter int MAXV = 15
) (
  input  logic signed [NW-1:0] n,
  output logic                 ok
);
  always_comb begin
    ok = (int'(n) <= MAXV) && (int'(n) >= -MAXV);
  end
endmodule

// File: rtl/sdseg_digit_enc.sv
module sdseg_digit_enc
  import sdseg_pkg::*;
#(
  parameter int NSEG    = 4,
  parameter int NW      = 8,
  parameter bit TERNARY = 1'b0
) (
  input  logic signed [NW-1:0]     n,
  output logic        [2*NSEG-1:0] cmd
);
  localparam int MAXV = span_max(NSEG, TERNARY);

  generate
    if (TERNARY) begin : g_tern
      // Shift into the unsigned range, take plain ternary digits, subtract one.
      always_comb begin
        int r;
        cmd = '0;
        r = int'(n) + MAXV;
        for (int i = 0; i < NSEG; i++) begin
          case (r % 3)
            0:       cmd[2*i +: 2] = DIG_NEG;
            2:       cmd[2*i +: 2] = DIG_POS;
            default: cmd[2*i +: 2] = DIG_ZERO;
          endcase
          r = r / 3;
        end
      end
    end else begin : g_bin
      always_comb begin
        int mag;
        logic neg;
        cmd = '0;
        neg = n[NW-1];
        mag = neg ? -int'(n) : int'(n);
        for (int i = 0; i < NSEG; i++) begin
          if (((mag >> i) & 1) != 0) begin
            cmd[2*i +: 2] = neg ? DIG_NEG : DIG_POS;
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/sdseg_seq_mem.sv
module sdseg_seq_mem #(
  parameter int NW    = 8,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic        [AW-1:0] wr_addr,
  input  logic signed [NW-1:0] wr_data,
  input  logic                 play_en,
  input  logic                 adv,
  output logic signed [NW-1:0] rd_data
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic signed [NW-1:0] mem [DEPTH];
  logic [AW-1:0] ptr_q;
  logic [AW-1:0] ptr_d;
  logic          wr_hit;

  always_comb begin
    wr_hit = wr_en && (int'(wr_addr) < DEPTH);
    if (!play_en) begin
      ptr_d = '0;
    end else if (adv) begin
      ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end else begin
      ptr_d = ptr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else begin
      ptr_q <= ptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_hit) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign rd_data = mem[ptr_q];
endmodule

// File: rtl/sdseg_bias_enc.sv
module sdseg_bias_enc
  import sdseg_pkg::*;
#(
  parameter int NSEG      = 4,
  parameter int NW        = 8,
  parameter bit TERNARY   = 1'b0,
  parameter int SEQ_DEPTH = 8,
  localparam int AW       = $clog2(SEQ_DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 play_en,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [NW-1:0] in_n,
  input  logic                 sample_tick,
  input  logic                 wr_en,
  input  logic        [AW-1:0] wr_addr,
  input  logic signed [NW-1:0] wr_data,
  output logic [2*NSEG-1:0]    cmd,
  output logic                 upd,
  output logic                 err
);
  localparam int MAXV = span_max(NSEG, TERNARY);

  logic                 take_in;
  logic                 take_seq;
  logic                 load;
  logic signed [NW-1:0] seq_n;
  logic signed [NW-1:0] src_n;
  logic                 src_ok;
  logic [2*NSEG-1:0]    enc_cmd;

  logic [2*NSEG-1:0]    cmd_q, cmd_d;
  logic                 upd_q, upd_d;
  logic                 err_q, err_d;

  assign in_ready = !play_en;

  always_comb begin
    take_in  = in_valid && !play_en;
    take_seq = sample_tick && play_en;
    load     = take_in || take_seq;
    src_n    = play_en ? seq_n : in_n;
  end

  sdseg_seq_mem #(.NW(NW), .DEPTH(SEQ_DEPTH)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .play_en (play_en),
    .adv     (take_seq),
    .rd_data (seq_n)
  );

  sdseg_range_chk #(.NW(NW), .MAXV(MAXV)) u_rng (
    .n  (src_n),
    .ok (src_ok)
  );

  sdseg_digit_enc #(.NSEG(NSEG), .NW(NW), .TERNARY(TERNARY)) u_enc (
    .n   (src_n),
    .cmd (enc_cmd)
  );

  // Next state: the whole command word is replaced in one step or kept.
  always_comb begin
    cmd_d = cmd_q;
    upd_d = 1'b0;
    err_d = 1'b0;
    if (load) begin
      if (src_ok) begin
        cmd_d = enc_cmd;
        upd_d = 1'b1;
      end else begin
        err_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      upd_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      cmd_q <= cmd_d;
      upd_q <= upd_d;
      err_q <= err_d;
    end
  end

  assign cmd = cmd_q;
  assign upd = upd_q;
  assign err = err_q;
endmodule

// File: rtl/sdseg_bias_enc_chk.sv
module sdseg_bias_enc_chk #(
  parameter int NSEG    = 4,
  parameter bit TERNARY = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              play_en,
  input logic              in_valid,
  input logic              in_ready,
  input logic              sample_tick,
  input logic [2*NSEG-1:0] cmd,
  input logic              upd,
  input logic              err
);
  function automatic bit has_code(input logic [2*NSEG-1:0] c, input logic [1:0] code);
    bit f;
    f = 1'b0;
    for (int i = 0; i < NSEG; i++) begin
      if (c[2*i +: 2] == code) f = 1'b1;
    end
    return f;
  endfunction

  // R2: the unused code never appears
  p_digit_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !has_code(cmd, 2'b10));

  // R1: an accepted direct N always gets a response on the next edge
  p_accept_resp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (upd || err));

  // R8: a playback strobe always gets a response on the next edge
  p_tick_resp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (play_en && sample_tick) |=> (upd || err));

  // R10: with no live request, the next cycle is quiet
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !((in_valid && in_ready) || (play_en && sample_tick)) |=> !(upd || err));

  // R7: the command bus moves only with an update pulse
  p_cmd_moves_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmd) |-> upd);

  // R6: a rejection holds the commands and never coincides with an update
  p_reject_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ($stable(cmd) && !upd));

  generate
    if (!TERNARY) begin : g_bin_chk
      // R4: binary commands never mix signs
      p_one_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(has_code(cmd, 2'b01) && has_code(cmd, 2'b11)));
    end
  endgenerate
endmodule

bind sdseg_bias_enc sdseg_bias_enc_chk #(.NSEG(NSEG), .TERNARY(TERNARY)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .play_en     (play_en),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .sample_tick (sample_tick),
  .cmd         (cmd),
  .upd         (upd),
  .err         (err)
);

// File: tb/sdseg_bias_enc_tb.sv
module sdseg_bias_enc_tb;
  localparam int NSEG = 4;
  localparam int NW   = 8;
  localparam int DEP  = 8;
  localparam int AW   = 3;
  localparam int MB   = 15;
  localparam int MT   = 40;

  logic clk;
  logic rst_n;
  logic play_en, in_valid, sample_tick, wr_en;
  logic signed [NW-1:0] in_n, wr_data;
  logic [AW-1:0] wr_addr;
  logic rdy_b, rdy_t, upd_b, upd_t, err_b, err_t;
  logic [2*NSEG-1:0] cmd_b, cmd_t;

  int checks = 0;
  int failures = 0;
  int last_b = 0;
  int last_t = 0;
  int seq [DEP];
  bit done = 1'b0;

  sdseg_bias_enc #(.NSEG(NSEG), .NW(NW), .TERNARY(1'b0), .SEQ_DEPTH(DEP)) u_dut (
    .clk(clk), .rst_n(rst_n), .play_en(play_en), .in_valid(in_valid), .in_ready(rdy_b),
    .in_n(in_n), .sample_tick(sample_tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cmd(cmd_b), .upd(upd_b), .err(err_b));

  sdseg_bias_enc #(.NSEG(NSEG), .NW(NW), .TERNARY(1'b1), .SEQ_DEPTH(DEP)) u_dut_tern (
    .clk(clk), .rst_n(rst_n), .play_en(play_en), .in_valid(in_valid), .in_ready(rdy_t),
    .in_n(in_n), .sample_tick(sample_tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cmd(cmd_t), .upd(upd_t), .err(err_t));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic expect_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Canonical binary command for v (R4), computed arithmetically
  function automatic int bin_vec(input int v);
    int a;
    int vec;
    a = (v < 0) ? -v : v;
    vec = 0;
    for (int i = 0; i < NSEG; i++) begin
      if (((a >> i) & 1) != 0) vec = vec | ((v < 0 ? 3 : 1) << (2 * i));
    end
    return vec;
  endfunction

  // Weighted sum of a command word; 9999 marks an illegal code (R2)
  function automatic int decode(input logic [2*NSEG-1:0] c, input bit tern);
    int w;
    int s;
    w = 1;
    s = 0;
    for (int i = 0; i < NSEG; i++) begin
      case (c[2*i +: 2])
        2'b01: s = s + w;
        2'b11: s = s - w;
        2'b00: s = s;
        default: return 9999;
      endcase
      w = tern ? w * 3 : w * 2;
    end
    return s;
  endfunction

  // Checks both instances after a request carrying value v (or no request)
  task automatic check_resp(input string req, input bit fired, input int v);
    bit ok_b;
    bit ok_t;
    ok_b = (v <= MB) && (v >= -MB);
    ok_t = (v <= MT) && (v >= -MT);
    if (fired && ok_b) last_b = v;
    if (fired && ok_t) last_t = v;
    expect_eq({req, " bin upd"}, int'(upd_b), int'(fired && ok_b));
    expect_eq({req, " bin err R6"}, int'(err_b), int'(fired && !ok_b));
    expect_eq({req, " bin cmd R4"}, int'(cmd_b), bin_vec(last_b));
    expect_eq({req, " bin sum R3"}, decode(cmd_b, 1'b0), last_b);
    expect_eq({req, " tern upd"}, int'(upd_t), int'(fired && ok_t));
    expect_eq({req, " tern err R6"}, int'(err_t), int'(fired && !ok_t));
    expect_eq({req, " tern sum R5"}, decode(cmd_t, 1'b1), last_t);
  endtask

  task automatic send(input int v);
    @(negedge clk);
    in_valid = 1'b1;
    in_n = NW'(v);
    @(negedge clk);
    in_valid = 1'b0;
    check_resp("R1 direct", 1'b1, v);
  endtask

  task automatic tick(input int idx);
    @(negedge clk);
    sample_tick = 1'b1;
    @(negedge clk);
    sample_tick = 1'b0;
    check_resp("R8 R9 playback", 1'b1, seq[idx]);
  endtask

  initial begin
    rst_n = 1'b0;
    play_en = 1'b0;
    in_valid = 1'b0;
    sample_tick = 1'b0;
    wr_en = 1'b0;
    in_n = '0;
    wr_data = '0;
    wr_addr = '0;
    seq = '{7, 9, 13, 30, -4, -9, -13, -30};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    expect_eq("R11 bin cmd", int'(cmd_b), 0);
    expect_eq("R11 tern cmd", int'(cmd_t), 0);
    expect_eq("R11 upd", int'(upd_b | upd_t), 0);
    expect_eq("R11 err", int'(err_b | err_t), 0);
    expect_eq("R1 ready", int'(rdy_b & rdy_t), 1);

    // R1 R3 R4 R5 R6: every representable input value
    for (int v = -128; v < 128; v++) send(v);

    // R7: idle cycles hold commands
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check_resp("R7 idle", 1'b0, 0);
    end

    // R10: strobe ignored with playback off
    @(negedge clk);
    sample_tick = 1'b1;
    @(negedge clk);
    sample_tick = 1'b0;
    check_resp("R10 tick ignored", 1'b0, 0);

    // R8: load the sequence store
    for (int a = 0; a < DEP; a++) begin
      @(negedge clk);
      wr_en = 1'b1;
      wr_addr = AW'(a);
      wr_data = NW'(seq[a]);
    end
    @(negedge clk);
    wr_en = 1'b0;

    play_en = 1'b1;
    @(negedge clk);
    expect_eq("R10 ready low", int'(rdy_b | rdy_t), 0);
    // R10: direct input ignored during playback
    in_valid = 1'b1;
    in_n = NW'(3);
    @(negedge clk);
    in_valid = 1'b0;
    check_resp("R10 valid ignored", 1'b0, 0);

    // R8 R9: play more than two laps with idle gaps
    for (int k = 0; k < 2 * DEP + 3; k++) begin
      tick(k % DEP);
      if (k % 4 == 1) begin
        @(negedge clk);
        check_resp("R7 gap", 1'b0, 0);
      end
    end

    // R10: leaving playback rewinds to entry 0
    play_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    play_en = 1'b1;
    tick(0);
    tick(1);
    play_en = 1'b0;
    send(-15);
    send(16);
    send(-40);
    send(41);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule